// File: doc/BRIEF.md
# PI Phase Tracking Controller

This block closes a digital phase-tracking loop around a fine phase shifter that moves one step per pulse. Each signed error sample from a converter feeds a proportional-integral law. The law computes the phase the loop wants to reach. The block subtracts the phase it currently holds, and then sends that difference out as a train of single step pulses. Up pulses advance the shifter and down pulses retard it. In a continuous-wave ranging set-up the loop settles when the error reads zero. At that point the demodulation clock sits a quarter period away from the modulation, so the reported phase count is a direct measure of distance.

The controller does not drive a control word. It keeps its own count of the shifter position, and that count wraps around one full period. One full period is the configured number of steps, for example 10000 steps of 100 ps at a 1 MHz modulation. Error samples arrive slowly, in the order of 50 kHz, compared with the pulse rate of one per clock. A sample that arrives during a pulse train is therefore held and used once the train ends.

Top module: `phase_track_ctrl`

## Requirements
- R1: After reset, `phase` is 0, `busy` is 0 and neither step output is high.
- R2: For a consumed sample `e` (two's complement) and current count `c`, the target is `w = (kp*e + ki*(c+e)) >>> FRAC_SH`. Here `kp` and `ki` are unsigned with FRAC_SH fraction bits, and `>>>` is an arithmetic shift that rounds toward minus infinity. The block issues `w - c` pulses, up when positive and down when negative.
- R3: The pulse count of one update is limited in magnitude to `max_steps`, and the sign of the difference is kept.
- R4: At most one pulse is issued per clock, and `step_up` and `step_dn` are never high together. The `phase` output changes exactly in the cycles in which a pulse is shown, by one count in the pulse's direction.
- R5: An up pulse taken at count `range_lim-1` gives 0. A down pulse taken at 0 gives `range_lim-1`.
- R6: A sample that arrives while a train is running is held. It is consumed on the clock after the train ends, against the count reached by then. A later sample replaces an earlier one that has not yet been used.
- R7: While `enable` is low, no pulses are issued, `phase` holds, any running train is abandoned, and samples are discarded.
- R8: A sample strobed at clock edge k raises `busy` after edge k+1 when its count is non-zero. The first pulse shows after edge k+2. `busy` stays high until the last pulse of the train shows.
- R9: A sample whose difference is zero issues no pulses and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Loop enable |
| smp_valid | input | 1 | Error sample strobe |
| smp_err | input | ERR_W | Signed error sample |
| kp | input | GAIN_W | Proportional gain, FRAC_SH fraction bits |
| ki | input | GAIN_W | Integral gain, FRAC_SH fraction bits |
| range_lim | input | PH_W | Steps per full period (at least 1) |
| max_steps | input | STEP_W | Largest pulse count per update |
| step_up | output | 1 | One-cycle advance pulse |
| step_dn | output | 1 | One-cycle retard pulse |
| phase | output | PH_W | Current phase in steps |
| busy | output | 1 | Pulse train in progress |

## Verification
The bench keeps the default widths: a 10-bit error, 8-bit gains with four fraction bits, a 16-bit count and a 6-bit limit. At run time it sets a period of only 20 steps and a per-update limit of 5 or 7. Short trains therefore cross the wrap point in both directions, and they run into saturation. A gain of 16 gives unit gain, so a single sample decides the target exactly. Changing `kp` brings the proportional term in, and samples strobed in the middle of a train exercise the hold and replacement path.

// File: rtl/ptc_pkg.sv
// Shared types for the phase tracking controller.
package ptc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } ptc_state_t;
endpackage

// File: rtl/ptc_sample_hold.sv
// Holds the most recent error sample until the step generator is free.
// Assumes: a new strobe outranks a consume in the same cycle; when the loop
// is disabled, the held sample is dropped.
module ptc_sample_hold #(
    parameter int ERR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             smp_valid,
    input  logic [ERR_W-1:0] smp_err,
    input  logic             take,
    output logic             pend,
    output logic [ERR_W-1:0] held_err
);
    // Capture a new sample, or clear the flag once it has been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            held_err <= '0;
        end else if (!enable) begin
            pend <= 1'b0;
        end else if (smp_valid) begin
            pend     <= 1'b1;
            held_err <= smp_err;
        end else if (take) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ptc_pi_law.sv
// Combinational PI law: target = (kp*e + ki*(cur+e)) >>> FRAC_SH.
// Outputs the saturated step count and direction toward the target.
// Assumes: unsigned gains; the internal width leaves room for every product.
module ptc_pi_law #(
    parameter int ERR_W   = 10,
    parameter int GAIN_W  = 8,
    parameter int FRAC_SH = 4,
    parameter int PH_W    = 16,
    parameter int STEP_W  = 6
) (
    input  logic [ERR_W-1:0]  err,
    input  logic [PH_W-1:0]   cur,
    input  logic [GAIN_W-1:0] kp,
    input  logic [GAIN_W-1:0] ki,
    input  logic [STEP_W-1:0] max_steps,
    output logic [STEP_W-1:0] cnt,
    output logic              dir_up
);
    localparam int SUM_W = GAIN_W + PH_W + ERR_W + 2;

    logic signed [SUM_W-1:0] ev, cv, kpv, kiv, mx;
    logic signed [SUM_W-1:0] acc, wanted, delta, neg;

    assign ev  = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};
    assign cv  = {{(SUM_W-PH_W){1'b0}}, cur};
    assign kpv = {{(SUM_W-GAIN_W){1'b0}}, kp};
    assign kiv = {{(SUM_W-GAIN_W){1'b0}}, ki};
    assign mx  = {{(SUM_W-STEP_W){1'b0}}, max_steps};

    // Wanted phase and signed distance to it.
    always_comb begin
        acc    = kpv * ev + kiv * (cv + ev);
        wanted = acc >>> FRAC_SH;
        delta  = wanted - cv;
        neg    = -delta;
    end

    // Clamp the magnitude to max_steps while keeping the sign.
    always_comb begin
        dir_up = !delta[SUM_W-1];
        if (delta > mx) begin
            cnt = max_steps;
        end else if (neg > mx) begin
            cnt = max_steps;
        end else if (dir_up) begin
            cnt = delta[STEP_W-1:0];
        end else begin
            cnt = neg[STEP_W-1:0];
        end
    end
endmodule

// File: rtl/ptc_step_gen.sv
// Issues one step pulse per clock and tracks the wrapped phase count.
// Assumes: range_lim >= 1 and the count stays below range_lim.
module ptc_step_gen #(
    parameter int PH_W   = 16,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [STEP_W-1:0] load_cnt,
    input  logic              load_up,
    input  logic [PH_W-1:0]   range_lim,
    output logic              step_up,
    output logic              step_dn,
    output logic [PH_W-1:0]   phase,
    output logic              busy
);
    import ptc_pkg::*;

    ptc_state_t        state;
    logic [STEP_W-1:0] remain;
    logic              dir_q;
    logic [PH_W-1:0]   ph_inc, ph_dec;

    // Neighbouring counts with wrap at both ends of the period.
    always_comb begin
        ph_inc = (phase == range_lim - 1'b1) ? '0 : phase + 1'b1;
        ph_dec = (phase == '0) ? range_lim - 1'b1 : phase - 1'b1;
    end

    // Train sequencing, phase update and registered pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            remain  <= '0;
            dir_q   <= 1'b0;
            phase   <= '0;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
            if (!enable) begin
                state  <= ST_IDLE;
                remain <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start && load_cnt != '0) begin
                            state  <= ST_ISSUE;
                            remain <= load_cnt;
                            dir_q  <= load_up;
                        end
                    end
                    ST_ISSUE: begin
                        phase   <= dir_q ? ph_inc : ph_dec;
                        step_up <= dir_q;
                        step_dn <= !dir_q;
                        remain  <= remain - 1'b1;
                        if (remain == 1) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy = (state == ST_ISSUE);
endmodule

// File: rtl/phase_track_ctrl.sv
// Top of the PI phase tracking controller: holds samples, applies the PI
// law against its own phase count and sends the result as step pulses.
// Assumes: samples arrive far slower than the pulse rate.
module phase_track_ctrl #(
    parameter int ERR_W   = 10,
    parameter int GAIN_W  = 8,
    parameter int FRAC_SH = 4,
    parameter int PH_W    = 16,
    parameter int STEP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              smp_valid,
    input  logic [ERR_W-1:0]  smp_err,
    input  logic [GAIN_W-1:0] kp,
    input  logic [GAIN_W-1:0] ki,
    input  logic [PH_W-1:0]   range_lim,
    input  logic [STEP_W-1:0] max_steps,
    output logic              step_up,
    output logic              step_dn,
    output logic [PH_W-1:0]   phase,
    output logic              busy
);
    logic              pend, take, dir_up;
    logic [ERR_W-1:0]  held_err;
    logic [STEP_W-1:0] cnt;

    assign take = pend && !busy;

    ptc_sample_hold #(.ERR_W(ERR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .smp_valid(smp_valid), .smp_err(smp_err), .take(take),
        .pend(pend), .held_err(held_err)
    );

    ptc_pi_law #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .FRAC_SH(FRAC_SH),
        .PH_W(PH_W), .STEP_W(STEP_W)
    ) u_law (
        .err(held_err), .cur(phase), .kp(kp), .ki(ki),
        .max_steps(max_steps), .cnt(cnt), .dir_up(dir_up)
    );

    ptc_step_gen #(.PH_W(PH_W), .STEP_W(STEP_W)) u_steps (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(take),
        .load_cnt(cnt), .load_up(dir_up), .range_lim(range_lim),
        .step_up(step_up), .step_dn(step_dn), .phase(phase), .busy(busy)
    );
endmodule

// File: rtl/phase_track_ctrl_chk.sv
// Protocol checker for phase_track_ctrl, attached with bind.
module phase_track_ctrl_chk #(
    parameter int PH_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            step_up,
    input logic            step_dn,
    input logic [PH_W-1:0] phase,
    input logic [PH_W-1:0] range_lim,
    input logic            busy
);
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n) !(step_up && step_dn)); // R4
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(step_up || step_dn) |-> $stable(phase)); // R4
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) step_up |-> phase == (($past(phase) == $past(range_lim) - 1'b1) ? '0 : $past(phase) + 1'b1)); // R5
    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n) step_dn |-> phase == (($past(phase) == '0) ? $past(range_lim) - 1'b1 : $past(phase) - 1'b1)); // R5
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !step_up && !step_dn && $stable(phase)); // R7
    AST_PULSE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (step_up || step_dn) |-> $past(busy)); // R8
endmodule

bind phase_track_ctrl phase_track_ctrl_chk #(.PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_up(step_up),
    .step_dn(step_dn), .phase(phase), .range_lim(range_lim), .busy(busy)
);

// File: tb/phase_track_ctrl_test.sv
module phase_track_ctrl_test;
    localparam int ERR_W = 10, GAIN_W = 8, FRAC_SH = 4, PH_W = 16, STEP_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic smp_valid = 1'b0;
    logic [ERR_W-1:0] smp_err = '0;
    logic [GAIN_W-1:0] kp = '0;
    logic [GAIN_W-1:0] ki = 8'd16;
    logic [PH_W-1:0] range_lim = 16'd20;
    logic [STEP_W-1:0] max_steps = 6'd5;
    logic step_up, step_dn, busy;
    logic [PH_W-1:0] phase;

    int n_cmp = 0, n_bad = 0;
    bit comparing = 0, done = 0;

    // reference model state
    int m_phase, m_cnt, m_hold;
    bit m_busy, m_pend, m_dir, m_up, m_dn;

    always #10 clk = ~clk;

    phase_track_ctrl #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .FRAC_SH(FRAC_SH),
                       .PH_W(PH_W), .STEP_W(STEP_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
        .smp_err(smp_err), .kp(kp), .ki(ki), .range_lim(range_lim),
        .max_steps(max_steps), .step_up(step_up), .step_dn(step_dn),
        .phase(phase), .busy(busy)
    );

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_hold = 0;
            m_busy = 0; m_pend = 0; m_dir = 0; m_up = 0; m_dn = 0;
        end else begin
            bit take;
            int used;
            longint w, d;
            take = m_pend && !m_busy;
            used = m_hold;
            m_up = 0; m_dn = 0;
            if (!enable) m_pend = 0;
            else if (smp_valid) begin m_pend = 1; m_hold = $signed(smp_err); end
            else if (take) m_pend = 0;
            if (!enable) begin
                m_busy = 0; m_cnt = 0;
            end else if (!m_busy) begin
                if (take) begin
                    w = (longint'(kp) * used + longint'(ki) * (m_phase + used)) >>> FRAC_SH;
                    d = w - m_phase;
                    m_dir = (d >= 0);
                    if (d < 0) d = -d;
                    if (d > max_steps) d = max_steps;
                    if (d != 0) begin m_busy = 1; m_cnt = int'(d); end
                end
            end else begin
                if (m_dir) m_phase = (m_phase == range_lim - 1) ? 0 : m_phase + 1;
                else       m_phase = (m_phase == 0) ? range_lim - 1 : m_phase - 1;
                m_up = m_dir; m_dn = !m_dir;
                m_cnt--;
                if (m_cnt == 0) m_busy = 0;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare against the model, away from the active edge.
    always @(negedge clk) begin
        if (comparing && !done) begin
            chk("R4 step_up", step_up, m_up);
            chk("R4 step_dn", step_dn, m_dn);
            chk("R2 phase", phase, m_phase);
            chk("R8 busy", busy, m_busy);
        end
    end

    task automatic send(int e);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_err = ERR_W'(e);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 phase", phase, 0);
        chk("R1 busy", busy, 0);
        chk("R1 steps", step_up | step_dn, 0);
        rst_n = 1'b1;
        comparing = 1;
        @(negedge clk);
        enable = 1'b1;
        // R8 timing: strobe seen at edge k
        @(negedge clk);
        smp_valid = 1'b1; smp_err = ERR_W'(3);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R8 busy after k", busy, 0);
        @(negedge clk);
        chk("R8 busy after k+1", busy, 1);
        chk("R8 no pulse after k+1", step_up, 0);
        @(negedge clk);
        chk("R8 first pulse after k+2", step_up, 1);
        settle();
        chk("R2 unit gain up", phase, 3);
        send(-5);
        settle();
        chk("R5 wrap below zero", phase, 18);
        send(9);
        settle();
        chk("R3 saturated, R5 wrap up", phase, 3);
        kp = 8'd32; max_steps = 6'd7;
        send(2);
        settle();
        chk("R2 proportional term", phase, 9);
        kp = 8'd0;
        send(0);
        @(negedge clk);
        chk("R9 busy stays low", busy, 0);
        settle();
        chk("R9 phase unchanged", phase, 9);
        // R6: sample during a train, then a replacement
        send(4);
        send(-7);
        send(-2);
        settle();
        chk("R6 held sample applied after train", phase, 11);
        // R7: disabled loop
        enable = 1'b0;
        send(6);
        settle();
        chk("R7 phase held while disabled", phase, 11);
        enable = 1'b1;
        settle();
        chk("R7 discarded sample not applied", phase, 11);
        send(5);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        settle();
        chk("R7 train abandoned", busy, 0);
        enable = 1'b1;
        settle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule